// File: doc/BRIEF.md
# Bus Transfer Error Termination Unit

This unit sits beside a split-phase bus, where the address phase and the data phase of a transfer are acknowledged separately. It decides when a transfer must end in error, and it then ends that transfer on behalf of the missing responder. At the start of each access it inspects the address-phase attributes: privilege level, direction, whether the target lies in internal register space, whether that location exists, the protection bits of the register, and the request line from the chip-select protection check. If the access is illegal, the unit terminates it in the next cycle. While a beat is running on the external bus, a programmable timer watches for the data acknowledge. If the limit passes with no acknowledge, the unit terminates the beat in error.

The internal address acknowledge is supplied only when the external responder has not already given one. A 32-bit access to a 16-bit port runs as two beats. Once any beat of such an access fails, an error flag stays set. Every later beat of the same access still runs on the bus, but it is ended with the internal error acknowledge instead of a normal one.

Top module: `bus_err_term`

## Requirements
- R1: When an access starts with an illegal attribute set and no external address acknowledge in that cycle, `int_aack` and `int_tea` are both high in the cycle after the start, `int_ta` is low, and `err_hold` goes high.
- R2: An error termination does not raise `int_aack` if `ext_aack` was high in the start cycle or in any earlier cycle of the same beat. `int_tea` is still raised.
- R3: When `split` is high at the start, the access has two beats. If the first beat fails, the second beat still waits for `ext_ta`, and it is ended with `int_tea` high and `int_ta` low.
- R4: `err_hold` stays high from the failing beat until the next access starts. At that start it takes the fault result of the new access.
- R5: An access with `int_space`=1 and `dec_hit`=0 (unimplemented internal location) is an error.
- R6: An internal access to an implemented register is an error if `acc_user`=1 with `reg_super`=1, or if `acc_write`=1 with `reg_ro`=1 or `reg_locked`=1. Reads of read-only or locked registers are legal, and so are user accesses to registers that are not supervisor-only.
- R7: `cs_err`=1 at the start makes the access an error in any address space. Register attributes do not matter when `int_space`=0.
- R8: A legal beat with no `ext_ta` ends in error on the clock edge that closes its `tmo_limit`-th cycle. Here the start edge counts as cycle 0. `int_aack` is raised with the error unless R2 applies.
- R9: A legal beat ended by `ext_ta` gives a one-cycle `int_ta` pulse in the next cycle. `ext_ta` is ignored while no access is active.
- R10: `int_ta`, `int_tea` and `int_aack` are single-cycle pulses per beat, and `int_ta` and `int_tea` are never high together.
- R11: After reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_start | input | 1 | Address phase of a new access is valid |
| split | input | 1 | Access runs as two beats on a 16-bit port |
| acc_user | input | 1 | Access made in user mode |
| acc_write | input | 1 | Access is a write |
| int_space | input | 1 | Address lies in internal register space |
| dec_hit | input | 1 | Internal address matches an implemented register |
| reg_super | input | 1 | Target register is supervisor-only |
| reg_ro | input | 1 | Target register is read-only |
| reg_locked | input | 1 | Target register is locked |
| cs_err | input | 1 | Chip-select protection check requests an error |
| ext_aack | input | 1 | External address acknowledge |
| ext_ta | input | 1 | External data acknowledge |
| tmo_limit | input | TMO_W | Timeout limit in cycles |
| int_aack | output | 1 | Internal address acknowledge |
| int_ta | output | 1 | Internal normal data acknowledge |
| int_tea | output | 1 | Internal transfer-error acknowledge |
| err_hold | output | 1 | Error flag of the current or last access |

## Verification
The hardest state to reach is the second beat of a split access after the first beat has already failed. From the outside that beat looks like an ordinary, well-behaved external transfer, yet it must still end in error, with no internal address acknowledge. The stimulus gets there in two ways. In the first, a split access is started with the protection request set, so the first beat fails at once. In the second, a split access is started legally and no acknowledge is given until the timer runs out. In both cases the bench then supplies a clean external address and data acknowledge for the second beat. Afterwards it checks that the flag persists while idle and clears when a fresh access starts.

// File: rtl/bterm_pkg.sv
package bterm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BEAT = 2'd1
  } bt_state_e;

  typedef struct packed {
    logic user;
    logic write;
    logic int_space;
    logic dec_hit;
    logic super_only;
    logic read_only;
    logic locked;
    logic cs_err;
  } bt_attr_t;

  // unimplemented internal location
  function automatic logic f_unimpl(bt_attr_t a);
    return a.int_space & ~a.dec_hit;
  endfunction

  // privilege / protection violation on an implemented register
  function automatic logic f_priv(bt_attr_t a);
    return a.int_space & a.dec_hit &
           ((a.user & a.super_only) | (a.write & (a.read_only | a.locked)));
  endfunction

endpackage

// File: rtl/bterm_fault_decode.sv
module bterm_fault_decode
  import bterm_pkg::*;
(
  input  bt_attr_t attr,
  output logic     fault_unimpl,
  output logic     fault_priv,
  output logic     fault_cs,
  output logic     fault
);

  always_comb begin
    fault_unimpl = f_unimpl(attr);
    fault_priv   = f_priv(attr);
    fault_cs     = attr.cs_err;
    fault        = fault_unimpl | fault_priv | fault_cs;
  end

endmodule

// File: rtl/bterm_beat_timer.sv
module bterm_beat_timer #(
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             run,
  input  logic [TMO_W-1:0] limit,
  output logic [TMO_W-1:0] cnt,
  output logic             expired
);

  localparam int CW = TMO_W + 1;

  // cycles elapsed in this beat (cnt+1) have reached the limit
  function automatic logic f_reached(logic [TMO_W-1:0] c, logic [TMO_W-1:0] lim);
    return ({1'b0, c} + CW'(1)) >= {1'b0, lim};
  endfunction

  always_comb expired = run & f_reached(cnt, limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (clear)            cnt <= '0;
    else if (run && !expired)  cnt <= cnt + TMO_W'(1);
  end

  p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && limit != '0 && $stable(limit)) |-> (cnt < limit));

endmodule

// File: rtl/bus_err_term.sv
module bus_err_term
  import bterm_pkg::*;
#(
  parameter int TMO_W      = 8,
  parameter int PORT_BEATS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_start,
  input  logic             split,
  input  logic             acc_user,
  input  logic             acc_write,
  input  logic             int_space,
  input  logic             dec_hit,
  input  logic             reg_super,
  input  logic             reg_ro,
  input  logic             reg_locked,
  input  logic             cs_err,
  input  logic             ext_aack,
  input  logic             ext_ta,
  input  logic [TMO_W-1:0] tmo_limit,
  output logic             int_aack,
  output logic             int_ta,
  output logic             int_tea,
  output logic             err_hold
);

  localparam int BW = (PORT_BEATS > 1) ? $clog2(PORT_BEATS) : 1;

  bt_state_e        state;
  logic [BW-1:0]    beats_left;
  logic             aack_seen;
  bt_attr_t         attr;
  logic             fault, fault_unimpl, fault_priv, fault_cs;
  logic [TMO_W-1:0] tmo_cnt;
  logic             tmo_expired;
  logic             in_beat, start_ok, beat_end, beat_tmo, beat_err;

  always_comb begin
    attr = '{user: acc_user, write: acc_write, int_space: int_space,
             dec_hit: dec_hit, super_only: reg_super, read_only: reg_ro,
             locked: reg_locked, cs_err: cs_err};
  end

  bterm_fault_decode u_dec (
    .attr        (attr),
    .fault_unimpl(fault_unimpl),
    .fault_priv  (fault_priv),
    .fault_cs    (fault_cs),
    .fault       (fault)
  );

  // named events for assertions
  always_comb begin
    in_beat  = (state == ST_BEAT);
    start_ok = (state == ST_IDLE) && cyc_start;
    beat_end = in_beat && (ext_ta || tmo_expired);
    beat_tmo = in_beat && tmo_expired && !ext_ta;
    beat_err = beat_tmo || (beat_end && err_hold);
  end

  bterm_beat_timer #(.TMO_W(TMO_W)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (!in_beat || beat_end),
    .run    (in_beat),
    .limit  (tmo_limit),
    .cnt    (tmo_cnt),
    .expired(tmo_expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      beats_left <= '0;
      aack_seen  <= 1'b0;
      err_hold   <= 1'b0;
      int_aack   <= 1'b0;
      int_ta     <= 1'b0;
      int_tea    <= 1'b0;
    end else begin
      int_aack <= 1'b0;
      int_ta   <= 1'b0;
      int_tea  <= 1'b0;
      if (start_ok) begin
        err_hold   <= fault;
        beats_left <= split ? BW'(PORT_BEATS - 1) : '0;
        aack_seen  <= ext_aack;
        state      <= ST_BEAT;
        if (fault) begin
          int_tea  <= 1'b1;
          int_aack <= !ext_aack;
          aack_seen <= 1'b0;
          if (!split) state <= ST_IDLE;
          else        beats_left <= BW'(PORT_BEATS - 2);
        end
      end else if (in_beat) begin
        aack_seen <= aack_seen | ext_aack;
        if (beat_end) begin
          if (beat_err) begin
            int_tea  <= 1'b1;
            int_aack <= beat_tmo && !(aack_seen || ext_aack);
          end else begin
            int_ta <= 1'b1;
          end
          if (beat_tmo) err_hold <= 1'b1;
          if (beats_left != '0) begin
            beats_left <= beats_left - BW'(1);
            aack_seen  <= 1'b0;
          end else begin
            state <= ST_IDLE;
          end
        end
      end
    end
  end

  p_ta_tea_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(int_ta && int_tea));

  p_aack_only_err_r1: assert property (@(posedge clk) disable iff (!rst_n)
    int_aack |-> int_tea);

  p_no_dup_aack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_beat && ext_aack) |=> !int_aack);

  p_clean_ta_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int_ta |-> !err_hold);

  p_fault_term_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ok && fault) |=> (int_tea && err_hold));

  p_sticky_beat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_end && err_hold) |=> (int_tea && !int_ta));

endmodule

// File: tb/bus_err_term_test.sv
module bus_err_term_test;

  localparam int TMO_W = 8;
  localparam int NV    = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cyc_start = 0, split = 0, acc_user = 0, acc_write = 0, int_space = 0;
  logic dec_hit = 0, reg_super = 0, reg_ro = 0, reg_locked = 0, cs_err = 0;
  logic ext_aack = 0, ext_ta = 0;
  logic [TMO_W-1:0] tmo_limit = 8'd5;
  logic int_aack, int_ta, int_tea, err_hold;

  int total = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bus_err_term #(.TMO_W(TMO_W), .PORT_BEATS(2)) uut (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .split(split),
    .acc_user(acc_user), .acc_write(acc_write), .int_space(int_space),
    .dec_hit(dec_hit), .reg_super(reg_super), .reg_ro(reg_ro),
    .reg_locked(reg_locked), .cs_err(cs_err), .ext_aack(ext_aack),
    .ext_ta(ext_ta), .tmo_limit(tmo_limit), .int_aack(int_aack),
    .int_ta(int_ta), .int_tea(int_tea), .err_hold(err_hold)
  );

  // {req[3:0], exp_fault, eaack, cs, locked, ro, super, hit, isp, write, user}
  localparam logic [13:0] VEC [NV] = '{
    14'b1001_0_0_0_1_0_1_0_0_1_1,  // R9 external, attrs ignored
    14'b0101_1_0_0_0_0_0_0_1_0_0,  // R5 unimplemented location
    14'b0110_1_0_0_0_0_1_1_1_0_1,  // R6 user to supervisor reg
    14'b0110_1_0_0_0_1_0_1_1_1_0,  // R6 write read-only
    14'b0110_1_1_0_1_0_0_1_1_1_0,  // R6 write locked, ext aack given
    14'b0110_0_0_0_1_0_0_1_1_0_0,  // R6 read locked legal
    14'b0110_0_0_0_0_1_0_1_1_0_0,  // R6 read read-only legal
    14'b0111_1_0_1_0_0_0_0_0_0_0,  // R7 cs error external
    14'b0010_1_1_1_0_0_0_0_0_0_0,  // R2 cs error with ext aack
    14'b0101_0_0_0_0_0_1_1_1_1_0,  // R5 implemented supervisor write
    14'b0110_0_0_0_0_0_0_1_1_1_1   // R6 user write to plain reg
  };

  task automatic check(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic clear_attrs();
    split = 0; acc_user = 0; acc_write = 0; int_space = 0; dec_hit = 0;
    reg_super = 0; reg_ro = 0; reg_locked = 0; cs_err = 0; ext_aack = 0;
  endtask

  // drives a start for one cycle; returns just after the start edge
  task automatic start_access(logic [9:0] a, logic sp);
    @(negedge clk);
    {ext_aack, cs_err, reg_locked, reg_ro, reg_super, dec_hit, int_space,
     acc_write, acc_user} = a[8:0];
    split = sp;
    cyc_start = 1;
    @(negedge clk);
    cyc_start = 0;
    clear_attrs();
  endtask

  task automatic pulse_ta(logic with_aack);
    ext_ta = 1; ext_aack = with_aack;
    @(negedge clk);
    ext_ta = 0; ext_aack = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, total);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; errors++;
      $display("FAIL R11 watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    #1;
    check("R11 reset aack", int_aack, 0);
    check("R11 reset ta", int_ta, 0);
    check("R11 reset tea", int_tea, 0);
    check("R11 reset hold", err_hold, 0);
    repeat (3) @(negedge clk);
    rst_n = 1;

    // vector table
    for (int i = 0; i < NV; i++) begin
      logic [13:0] v;
      string tg;
      logic ef;
      v  = VEC[i];
      ef = v[9];
      tg = $sformatf("R%0d vec%0d", v[13:10], i);
      start_access(v[9:0], 1'b0);
      check({tg, " tea"}, int_tea, ef);
      check({tg, " aack"}, int_aack, ef & ~v[8]);
      check({tg, " ta"}, int_ta, 0);
      check({tg, " hold"}, err_hold, ef);
      if (!ef) begin
        pulse_ta(1'b1);
        check({tg, " ta end"}, int_ta, 1);
        check({tg, " tea end"}, int_tea, 0);
      end
      @(negedge clk);
      check({tg, " R10 pulse ta"}, int_ta, 0);
      check({tg, " R10 pulse tea"}, int_tea, 0);
    end

    // R9: ext_ta while idle is ignored
    pulse_ta(1'b0);
    check("R9 idle ta ignored", int_ta, 0);
    check("R9 idle tea quiet", int_tea, 0);

    // R8 + R1: timeout without ext aack
    start_access(10'b0, 1'b0);
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      check($sformatf("R8 no tea at cycle %0d", k), int_tea, 0);
    end
    @(negedge clk);
    check("R8 timeout tea", int_tea, 1);
    check("R1 timeout aack", int_aack, 1);
    check("R4 timeout hold", err_hold, 1);
    @(negedge clk);
    check("R10 tea one cycle", int_tea, 0);

    // R8 + R2: timeout after ext aack in the beat
    start_access(10'b0, 1'b0);
    check("R4 cleared by new start", err_hold, 0);
    ext_aack = 1;
    @(negedge clk);
    ext_aack = 0;
    repeat (3) @(negedge clk);
    check("R8 still waiting", int_tea, 0);
    @(negedge clk);
    check("R8 tea after aack", int_tea, 1);
    check("R2 no internal aack", int_aack, 0);
    @(negedge clk);

    // R3: split, first beat fails on protection request
    start_access(10'b00_1000_0000, 1'b1);
    check("R3 beat1 tea", int_tea, 1);
    check("R1 beat1 aack", int_aack, 1);
    pulse_ta(1'b1);
    check("R3 beat2 tea", int_tea, 1);
    check("R3 beat2 no ta", int_ta, 0);
    check("R2 beat2 no aack", int_aack, 0);
    @(negedge clk);
    check("R4 hold while idle", err_hold, 1);
    check("R10 quiet after split", int_tea, 0);
    start_access(10'b0, 1'b0);
    check("R4 hold cleared", err_hold, 0);
    pulse_ta(1'b1);
    check("R9 normal ta", int_ta, 1);

    // R3: split, first beat times out
    start_access(10'b0, 1'b1);
    repeat (4) @(negedge clk);
    @(negedge clk);
    check("R3 beat1 timeout tea", int_tea, 1);
    pulse_ta(1'b1);
    check("R3 beat2 forced tea", int_tea, 1);
    check("R3 beat2 forced no ta", int_ta, 0);
    @(negedge clk);

    // R3 control: legal split gives two normal acks
    start_access(10'b0, 1'b1);
    pulse_ta(1'b1);
    check("R3 legal beat1 ta", int_ta, 1);
    pulse_ta(1'b1);
    check("R3 legal beat2 ta", int_ta, 1);
    check("R3 legal beat2 tea", int_tea, 0);
    pulse_ta(1'b0);
    check("R9 after split idle", int_ta, 0);

    finish_run();
  end

endmodule